// File: doc/BRIEF.md
# Varying Slot Remapper

This stage sits between the store that holds one vertex's shader outputs and the unit that preloads coefficient registers. Vertex output words arrive one per cycle, each tagged with its output index. The stage re-emits them in interpolation-slot order, tags each slot with its slot number, and marks it as either a plain 32-bit value or a packed pair of 16-bit values.

The vertex output layout is fixed. Indices 0..3 hold the position as X, Y, Z, W. User varyings follow, 32-bit ones first and then packed 16-bit pairs. Each precision is grouped as smooth, flat, linear. Point size and up to sixteen clip distances come last when they are present.

In the slot stream, W always takes slot 0. Z optionally takes slot 1. The user varyings follow in their output order. Point size and clip distances are consumed and discarded. A combinational output gives the number of 32-bit slots, counting W, for the preload header. A one-cycle done pulse marks the end of each vertex.

Top module: `vary_remap`

## Requirements
- R1: While reset is asserted and after its release with no input, `out_valid` and `done` are low.
- R2: The word with index 3 (W) appears as slot 0 with `out_is16` low, on the outputs in the cycle after the clock edge that accepts it.
- R3: With `cfg_z_en` high, the word with index 2 (Z) appears as slot 1 with `out_is16` low, one cycle after W.
- R4: With `cfg_z_en` low, the word with index 2 never appears on the outputs, and the first user varying takes slot 1.
- R5: A user varying with index k, where 4 <= k < 4 + (sum of the six group counts), appears as slot k - 3 + `cfg_z_en` with unchanged data, two cycles after it is accepted. Slots leave in ascending order.
- R6: A user varying is flagged `out_is16` high exactly when k - 4 is at least the sum of the three 32-bit group counts.
- R7: `n32_slots` equals 1 + `cfg_z_en` + the sum of the three 32-bit group counts.
- R8: Position X and Y (indices 0 and 1), the point size word and the clip distance words produce no output slot.
- R9: `done` is high for exactly one cycle per vertex. That cycle is three cycles after the edge that accepts the final word, whose index is 4 + user count + `cfg_psize` + `cfg_nclip` - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sm32 | input | CW | Count of 32-bit smooth varyings |
| cfg_fl32 | input | CW | Count of 32-bit flat varyings |
| cfg_ln32 | input | CW | Count of 32-bit linear varyings |
| cfg_sm16 | input | CW | Count of packed 16-bit smooth pairs |
| cfg_fl16 | input | CW | Count of packed 16-bit flat pairs |
| cfg_ln16 | input | CW | Count of packed 16-bit linear pairs |
| cfg_z_en | input | 1 | Forward Z into slot 1 |
| cfg_psize | input | 1 | Point size word present |
| cfg_nclip | input | 5 | Number of clip distance words, 0..16 |
| in_valid | input | 1 | Input word valid |
| in_idx | input | IW | Vertex output index of the word |
| in_data | input | 32 | Vertex output word |
| out_valid | output | 1 | Slot word valid |
| out_slot | output | SW | Slot number |
| out_data | output | 32 | Slot word |
| out_is16 | output | 1 | Slot holds a packed 16-bit pair |
| done | output | 1 | One-cycle end-of-vertex pulse |
| n32_slots | output | SW | Number of 32-bit slots, including W |

## Verification
The assertions rely on three conditions. The configuration stays stable for the length of a vertex. The words of each vertex arrive exactly once and in ascending index order, starting from 0. The next vertex begins only after the previous one's final word has been accepted. Under these conditions no two sources compete for the output register. The bench drives every vertex as the full ascending index run its configuration implies. It holds the configuration steady from before the first word until the done pulse has been observed. In some configurations it inserts idle cycles between words.

// File: rtl/vary_remap.sv
module vary_remap #(
  parameter int CW = 4,
  parameter int IW = 7,
  parameter int SW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_sm32,
  input  logic [CW-1:0] cfg_fl32,
  input  logic [CW-1:0] cfg_ln32,
  input  logic [CW-1:0] cfg_sm16,
  input  logic [CW-1:0] cfg_fl16,
  input  logic [CW-1:0] cfg_ln16,
  input  logic          cfg_z_en,
  input  logic          cfg_psize,
  input  logic [4:0]    cfg_nclip,
  input  logic          in_valid,
  input  logic [IW-1:0] in_idx,
  input  logic [31:0]   in_data,
  output logic          out_valid,
  output logic [SW-1:0] out_slot,
  output logic [31:0]   out_data,
  output logic          out_is16,
  output logic          done,
  output logic [SW-1:0] n32_slots
);
  localparam logic [IW-1:0] POS_WORDS = IW'(4);

  logic [IW-1:0] n32u, n16u, vend, last_idx, uoff;
  logic          is_user;

  assign n32u     = IW'(cfg_sm32) + IW'(cfg_fl32) + IW'(cfg_ln32);
  assign n16u     = IW'(cfg_sm16) + IW'(cfg_fl16) + IW'(cfg_ln16);
  assign vend     = POS_WORDS + n32u + n16u;
  assign last_idx = vend + IW'(cfg_psize) + IW'(cfg_nclip) - IW'(1);
  assign uoff     = in_idx - POS_WORDS;
  assign is_user  = (in_idx >= POS_WORDS) && (in_idx < vend);
  assign n32_slots = SW'(n32u) + SW'(1) + SW'(cfg_z_en);

  logic [31:0]   z_hold, d_data;
  logic          z_pend, d_valid, d_is16;
  logic [SW-1:0] d_slot;
  logic [2:0]    fin_sh;

  assign done = fin_sh[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      z_pend    <= 1'b0;
      d_valid   <= 1'b0;
      out_valid <= 1'b0;
      fin_sh    <= '0;
    end else begin
      fin_sh  <= {fin_sh[1:0], in_valid && (in_idx == last_idx)};
      z_pend  <= in_valid && (in_idx == IW'(3)) && cfg_z_en;
      d_valid <= in_valid && is_user;
      if (in_valid && in_idx == IW'(3)) begin
        out_valid <= 1'b1;
        out_slot  <= '0;
        out_data  <= in_data;
        out_is16  <= 1'b0;
      end else if (z_pend) begin
        out_valid <= 1'b1;
        out_slot  <= SW'(1);
        out_data  <= z_hold;
        out_is16  <= 1'b0;
      end else if (d_valid) begin
        out_valid <= 1'b1;
        out_slot  <= d_slot;
        out_data  <= d_data;
        out_is16  <= d_is16;
      end else begin
        out_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_idx == IW'(2)) z_hold <= in_data;
    d_slot <= SW'(uoff) + SW'(1) + SW'(cfg_z_en);
    d_data <= in_data;
    d_is16 <= uoff >= n32u;
  end

  assert_w_slot0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_idx == IW'(3)) |=>
      (out_valid && out_slot == '0 && !out_is16 && out_data == $past(in_data)));

  assert_z_slot1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_idx == IW'(3) && cfg_z_en) |=> ##1 (out_valid && out_slot == SW'(1)));

  assert_drop_tail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_idx >= vend) |=> ##1 !out_valid);

  assert_is16_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_slot >= n32_slots) |-> out_is16);

  assert_is16_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_slot < n32_slots) |-> !out_is16);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/tb_vary_remap.sv
module tb_vary_remap;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] sm32, fl32, ln32, sm16, fl16, ln16;
  logic z_en, psize;
  logic [4:0] nclip;
  logic in_valid = 1'b0;
  logic [6:0] in_idx = '0;
  logic [31:0] in_data = '0;
  logic out_valid, out_is16, done;
  logic [6:0] out_slot, n32_slots;
  logic [31:0] out_data;

  always #4 clk = ~clk;

  vary_remap dut (.clk(clk), .rst_n(rst_n), .cfg_sm32(sm32), .cfg_fl32(fl32), .cfg_ln32(ln32),
    .cfg_sm16(sm16), .cfg_fl16(fl16), .cfg_ln16(ln16), .cfg_z_en(z_en), .cfg_psize(psize),
    .cfg_nclip(nclip), .in_valid(in_valid), .in_idx(in_idx), .in_data(in_data),
    .out_valid(out_valid), .out_slot(out_slot), .out_data(out_data), .out_is16(out_is16),
    .done(done), .n32_slots(n32_slots));

  int total = 0, bad = 0, ncyc = 0, lcnt = 0, dcnt = 0, dcyc = 0;
  int lslot [0:255];
  logic [31:0] ldat [0:255];
  logic lis16 [0:255];
  int lcyc [0:255];

  always @(negedge clk) begin
    ncyc = ncyc + 1;
    if (out_valid && lcnt < 256) begin
      lslot[lcnt] = int'(out_slot); ldat[lcnt] = out_data;
      lis16[lcnt] = out_is16; lcyc[lcnt] = ncyc; lcnt = lcnt + 1;
    end
    if (done) begin dcnt = dcnt + 1; dcyc = ncyc; end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wd(input int id, input int k);
    return {8'hC5, id[15:0], k[7:0]};
  endfunction

  task automatic run_cfg(input int id, input int a, input int b, input int c, input int d,
                         input int e, input int f, input bit z, input bit p, input int nc,
                         input bit gap);
    int n32, nu, tw, t3, tl, exp_cnt, pos, zseen;
    @(negedge clk); #1;
    sm32 = 4'(a); fl32 = 4'(b); ln32 = 4'(c); sm16 = 4'(d); fl16 = 4'(e); ln16 = 4'(f);
    z_en = z; psize = p; nclip = 5'(nc);
    lcnt = 0; dcnt = 0; t3 = 0; tl = 0;
    n32 = a + b + c; nu = n32 + d + e + f; tw = 4 + nu + p + nc;
    #1;
    chk(int'(n32_slots) == 1 + z + n32, "R7 n32_slots", n32_slots, 1 + z + n32);
    for (int k = 0; k < tw; k++) begin
      @(negedge clk); #1;
      in_valid = 1'b1; in_idx = 7'(k); in_data = wd(id, k);
      if (k == 3) t3 = ncyc;
      tl = ncyc;
      if (gap && k[0]) begin @(negedge clk); #1; in_valid = 1'b0; end
    end
    @(negedge clk); #1; in_valid = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    exp_cnt = 1 + z + nu;
    chk(lcnt == exp_cnt, "R8 slot count", lcnt, exp_cnt);
    if (lcnt >= 1) begin
      chk(lslot[0] == 0 && ldat[0] == wd(id, 3) && !lis16[0], "R2 W slot0", ldat[0], wd(id, 3));
      chk(lcyc[0] == t3 + 1, "R2 W timing", lcyc[0], t3 + 1);
    end
    if (z && lcnt >= 2)
      chk(lslot[1] == 1 && ldat[1] == wd(id, 2) && !lis16[1] && lcyc[1] == t3 + 2,
          "R3 Z slot1", ldat[1], wd(id, 2));
    zseen = 0;
    for (int i = 0; i < lcnt; i++) if (ldat[i] == wd(id, 2)) zseen++;
    if (!z) chk(zseen == 0, "R4 Z dropped", zseen, 0);
    pos = 1 + z;
    for (int k = 4; k < 4 + nu; k++) begin
      if (pos < lcnt) begin
        chk(lslot[pos] == k - 3 + z && ldat[pos] == wd(id, k),
            (!z && k == 4) ? "R4 first varying slot1" : "R5 varying slot",
            lslot[pos], k - 3 + z);
        chk(lis16[pos] == (k - 4 >= n32), "R6 is16 flag", lis16[pos], k - 4 >= n32);
      end
      pos++;
    end
    chk(dcnt == 1, "R9 done count", dcnt, 1);
    chk(dcyc == tl + 3, "R9 done timing", dcyc, tl + 3);
  endtask

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int id;
    {sm32, fl32, ln32, sm16, fl16, ln16} = '0;
    z_en = 1'b1; psize = 1'b0; nclip = '0;
    repeat (3) @(negedge clk);
    chk(!out_valid && !done, "R1 in reset", out_valid, 0);
    #1; rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!out_valid && !done, "R1 after reset", out_valid, 0);
    id = 0;
    for (int m = 0; m < 64; m++)
      for (int zz = 0; zz < 2; zz++)
        for (int pp = 0; pp < 2; pp++)
          for (int cc = 0; cc < 3; cc++) begin
            run_cfg(id, m & 1, (m >> 1) & 1, (m >> 2) & 1, (m >> 3) & 1, (m >> 4) & 1,
                    (m >> 5) & 1, zz[0], pp[0], (cc == 2) ? 16 : cc, (id % 3) == 0);
            id++;
          end
    run_cfg(id, 15, 15, 15, 15, 15, 15, 1'b1, 1'b1, 16, 1'b0); id++;
    run_cfg(id, 15, 0, 7, 0, 15, 3, 1'b0, 1'b1, 16, 1'b1); id++;
    run_cfg(id, 0, 0, 0, 9, 0, 0, 1'b0, 1'b0, 0, 1'b0); id++;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule